// File: doc/BRIEF.md
# Buzzer Pin-Pair Output Selector

This block sits between two adjacent general-purpose port bits and their pads. In normal operation each bit is a plain push-pull output that drives its own data latch bit, or an input whose pad level is read back. When the buzzer option is on, both pins can instead drive a complementary square-wave pair that can feed a piezo element directly.

The square wave comes from a divider flop. That flop changes state on each overflow pulse of an external timer, so its output runs at half the overflow rate. The data bit of the first pin is the only on/off control for the tone on both pins. The data bit of the second pin has no effect on its pad while buzzer mode is on. Direction control and reads work the same way in both modes.

Top module: `bzmux_top`

## Requirements
- R1: After reset the divider signal is 0. With buzzer mode on, `dat[0]`=1 and both pins set as outputs, the first reset cycle therefore shows `pad_o`=2'b10: index 1 is high and index 0 is low.
- R2: The divider signal changes state on each clock edge where `tmr_ovf` is high. It holds its value on every other edge. With the default prescale of 1, each pulse gives one toggle.
- R3: A direction bit of 1 makes that pin an input, so `pad_oe[i]`=0. A direction bit of 0 makes it an output, so `pad_oe[i]`=1. Buzzer mode does not change the enables.
- R4: With `bz_en`=0, `pad_o[i]` equals `dat[i]` for both pins. The divider has no effect.
- R5: With `bz_en`=1 and `dat[0]`=1, `pad_o[0]` equals the divider signal and `pad_o[1]` equals its complement.
- R6: With `bz_en`=1 and `dat[0]`=0, both `pad_o` bits are 0, whatever the value of `dat[1]`.
- R7: `rd_o[i]` returns `pad_i[i]` when pin i is an input and `dat[i]` when it is an output. This holds in both buzzer and normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_ovf | input | 1 | Timer overflow pulse, one cycle wide |
| bz_en | input | 1 | Buzzer option: 1 selects buzzer mode |
| dat | input | 2 | Data latch bits; index 0 is the first pin |
| dir | input | 2 | Direction bits: 1 = input, 0 = output |
| pad_i | input | 2 | Pad levels seen at the input buffers |
| pad_o | output | 2 | Values driven toward the pads |
| pad_oe | output | 2 | Pad output enables, 1 = drive |
| rd_o | output | 2 | Values returned when the port is read |

## Verification
Directed sequences first establish the reset phase of the divider. They then count toggles across bursts of overflow pulses and across gaps with no pulse, which separates a toggle flop from a follower or a stuck flop. Random mixes of mode, latch data, direction and pad levels then switch among normal, muted and sounding states. These mixes show whether the second pin wrongly follows its own latch bit in buzzer mode, and whether it has the wrong phase. Reads are compared with pad and latch values under every direction setting, so a mode-dependent read path is caught.

// File: rtl/bzmux_pkg.sv
package bzmux_pkg;
   // Role of a pin within the pair
   typedef enum logic {
      PIN_LEAD   = 1'b0,
      PIN_FOLLOW = 1'b1
   } bz_role_e;

   localparam int unsigned NPIN = 2;

   // Tone driven by a pin of the given role
   function automatic logic tone_of(input bz_role_e role, input logic pfd);
      return (role == PIN_FOLLOW) ? ~pfd : pfd;
   endfunction
endpackage

// File: rtl/bzmux_pfd.sv
module bzmux_pfd #(
   parameter int unsigned PRESCALE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf_i,
   output logic pfd_o
);
   generate
      if (PRESCALE < 1) begin : g_bad
         $error("bzmux_pfd: PRESCALE must be at least 1");
      end else if (PRESCALE == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pfd_o <= 1'b0;
            else if (ovf_i) pfd_o <= ~pfd_o;
         end
      end else begin : g_count
         localparam int unsigned CW = $clog2(PRESCALE);
         localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt   <= '0;
               pfd_o <= 1'b0;
            end else if (ovf_i) begin
               if (cnt == LAST) begin
                  cnt   <= '0;
                  pfd_o <= ~pfd_o;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/bzmux_pin.sv
module bzmux_pin
   import bzmux_pkg::*;
#(
   parameter bz_role_e ROLE       = PIN_LEAD,
   parameter bit       DIR_IN_LVL = 1'b1
) (
   input  logic bz_en,
   input  logic gate,
   input  logic dat,
   input  logic dir,
   input  logic pad_i,
   input  logic pfd,
   output logic pad_o,
   output logic oe,
   output logic rd
);
   logic is_in;
   logic tone;

   assign is_in = (dir == DIR_IN_LVL);
   assign oe    = ~is_in;
   assign tone  = tone_of(ROLE, pfd);

   always_comb begin
      if (bz_en) pad_o = gate & tone;
      else       pad_o = dat;
   end

   assign rd = is_in ? pad_i : dat;
endmodule

// File: rtl/bzmux_top.sv
module bzmux_top
   import bzmux_pkg::*;
#(
   parameter int unsigned OVF_PRESCALE = 1,
   parameter bit          DIR_IN_LVL   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tmr_ovf,
   input  logic       bz_en,
   input  logic [1:0] dat,
   input  logic [1:0] dir,
   input  logic [1:0] pad_i,
   output logic [1:0] pad_o,
   output logic [1:0] pad_oe,
   output logic [1:0] rd_o
);
   logic pfd;

   bzmux_pfd #(.PRESCALE(OVF_PRESCALE)) u_pfd (
      .clk   (clk),
      .rst_n (rst_n),
      .ovf_i (tmr_ovf),
      .pfd_o (pfd)
   );

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      bzmux_pin #(
         .ROLE       ((i == 0) ? PIN_LEAD : PIN_FOLLOW),
         .DIR_IN_LVL (DIR_IN_LVL)
      ) u_pin (
         .bz_en (bz_en),
         .gate  (dat[0]),
         .dat   (dat[i]),
         .dir   (dir[i]),
         .pad_i (pad_i[i]),
         .pfd   (pfd),
         .pad_o (pad_o[i]),
         .oe    (pad_oe[i]),
         .rd    (rd_o[i])
      );
   end
endmodule

// File: rtl/bzmux_chk.sv
module bzmux_chk #(
   parameter int unsigned OVF_PRESCALE = 1,
   parameter bit          DIR_IN_LVL   = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       tmr_ovf,
   input logic       bz_en,
   input logic [1:0] dat,
   input logic [1:0] dir,
   input logic [1:0] pad_i,
   input logic [1:0] pad_o,
   input logic [1:0] pad_oe,
   input logic [1:0] rd_o,
   input logic       pfd
);
   // R2
   pfd_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (OVF_PRESCALE == 1 && tmr_ovf) |=> (pfd != $past(pfd)));
   // R2
   pfd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_ovf |=> $stable(pfd));
   // R3
   in_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir[0] == DIR_IN_LVL) |-> !pad_oe[0]);
   // R3
   out_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir[1] != DIR_IN_LVL) |-> pad_oe[1]);
   // R4
   plain_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bz_en |-> (pad_o == dat));
   // R5
   bz_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bz_en && dat[0]) |-> (pad_o[0] != pad_o[1]));
   // R6
   bz_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bz_en && !dat[0]) |-> (pad_o == 2'b00));
   // R7
   rd_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir[0] == DIR_IN_LVL) |-> (rd_o[0] == pad_i[0]));
endmodule

bind bzmux_top bzmux_chk #(
   .OVF_PRESCALE (OVF_PRESCALE),
   .DIR_IN_LVL   (DIR_IN_LVL)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tmr_ovf (tmr_ovf),
   .bz_en   (bz_en),
   .dat     (dat),
   .dir     (dir),
   .pad_i   (pad_i),
   .pad_o   (pad_o),
   .pad_oe  (pad_oe),
   .rd_o    (rd_o),
   .pfd     (pfd)
);

// File: tb/test_bzmux_top.sv
`timescale 1ns/1ps
module test_bzmux_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tmr_ovf = 1'b0;
   logic       bz_en = 1'b0;
   logic [1:0] dat = 2'b00;
   logic [1:0] dir = 2'b00;
   logic [1:0] pad_i = 2'b00;
   logic [1:0] pad_o, pad_oe, rd_o;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   logic mpfd = 1'b0;

   always #2 clk = ~clk;

   bzmux_top i_bzmux_top (
      .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .bz_en(bz_en),
      .dat(dat), .dir(dir), .pad_i(pad_i),
      .pad_o(pad_o), .pad_oe(pad_oe), .rd_o(rd_o)
   );

   function automatic logic [1:0] exp_pad(logic bz, logic [1:0] d, logic p);
      if (!bz)        return d;
      else if (!d[0]) return 2'b00;
      else            return {~p, p};
   endfunction

   function automatic logic [1:0] exp_rd(logic [1:0] dr, logic [1:0] pi, logic [1:0] d);
      logic [1:0] r;
      for (int k = 0; k < 2; k++) r[k] = dr[k] ? pi[k] : d[k];
      return r;
   endfunction

   task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic check_all();
      string t;
      t = !bz_en ? "R4 plain" : (dat[0] ? "R5 tone" : "R6 mute");
      check(t, pad_o, exp_pad(bz_en, dat, mpfd));
      check("R3 enable", pad_oe, ~dir);
      check("R7 read", rd_o, exp_rd(dir, pad_i, dat));
   endtask

   task automatic cyc(logic ov, logic bz, logic [1:0] d, logic [1:0] dr, logic [1:0] pi);
      @(negedge clk);
      tmr_ovf = ov; bz_en = bz; dat = d; dir = dr; pad_i = pi;
      @(posedge clk);
      #1;
      if (ov) mpfd = ~mpfd;
      check_all();
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      bz_en = 1'b1; dat = 2'b01; dir = 2'b00;
      #1;
      // R1: reset phase visible at the pads
      check("R1 reset", pad_o, 2'b10);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cyc(1'b0, 1'b1, 2'b01, 2'b00, 2'b00);
      check("R1 after reset", pad_o, 2'b10);
      // R2: one pulse toggles, a gap holds
      cyc(1'b1, 1'b1, 2'b01, 2'b00, 2'b00);
      check("R2 toggle", pad_o, 2'b01);
      cyc(1'b0, 1'b1, 2'b01, 2'b00, 2'b00);
      check("R2 hold", pad_o, 2'b01);
      cyc(1'b1, 1'b1, 2'b01, 2'b00, 2'b00);
      check("R2 toggle back", pad_o, 2'b10);
      // R6: dat[1] ignored while muted
      cyc(1'b0, 1'b1, 2'b10, 2'b00, 2'b11);
      check("R6 dat1 ignored", pad_o, 2'b00);
      // R5: second pin latch value does not matter
      cyc(1'b1, 1'b1, 2'b11, 2'b00, 2'b00);
      check("R5 follow complement", pad_o, 2'b01);
      // R4: divider ignored in plain mode
      cyc(1'b1, 1'b0, 2'b10, 2'b00, 2'b01);
      check("R4 plain data", pad_o, 2'b10);
      // R3/R7: inputs in buzzer mode
      cyc(1'b0, 1'b1, 2'b01, 2'b11, 2'b10);
      check("R3 inputs off", pad_oe, 2'b00);
      check("R7 pad read", rd_o, 2'b10);
      for (int n = 0; n < 400; n++) begin
         cyc(($urandom % 3) == 0, $urandom % 2, 2'($urandom), 2'($urandom), 2'($urandom));
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule